// File: doc/BRIEF.md
# Signalling Voltage Switch Sequencer

This block moves the signalling level of an SD card bus between 3.3 V and 1.8 V, and does it without software stepping through each stage. An initializer raises a request that names the target level. The sequencer then drives three controls: the card clock enable, the 1.8 V signalling enable and the bus power enable. It watches the four data line levels and a readback of the 1.8 V enable. The readback is needed because the external regulator may fail to hold the enable. When the sequence ends, the block pulses `done` with one of three statuses. Success and error have their usual meaning. Retry tells the initializer to withdraw its 1.8 V request bit (bit 24 of the operating-conditions word) and start initialization again.

Every wait is a whole number of milliseconds. A prescaler sized by the `CLK_KHZ` parameter counts these out, so a bench can shrink a millisecond to a few cycles. The sequencer is active only when the controller version code shows revision 3.00 or later. Below that revision every request succeeds at once and no control output changes.

Top module: `vsw_seq`

## Requirements
- R1: After a synchronous reset, the card clock enable is 1, bus power is 1, the 1.8 V enable is 0, and `busy` and `done` are 0.
- R2: When `ver_code` is below 2 (the code for revision 3.00), a request pulses `done` on the next cycle with status 00. `busy` never rises and no control output changes.
- R3: A 3.3 V request (`req_low`=0) clears the 1.8 V enable and waits 5 ms. The block then reports status 00 if the synchronized readback is 0 and status 01 (error) if it is 1.
- R4: A 1.8 V request (`req_low`=1) while the 1.8 V enable is already 1 changes nothing. It pulses `done` with status 00 on the next cycle, and `busy` stays low.
- R5: A 1.8 V request while the enable is 0 first drops the card clock enable. It then waits for the synchronizer depth plus one cycle and requires the data lines to read 0000. Any other value starts a power cycle.
- R6: With data lines at 0000, the block sets the 1.8 V enable while the card clock is off and waits 5 ms. A readback of 0 at that point starts a power cycle.
- R7: With the readback held at 1, the block turns the card clock back on and waits 1 ms. It reports status 00 only if the data lines then read 1111; otherwise it starts a power cycle.
- R8: A power cycle clears the 1.8 V enable and holds bus power at 0 for 1 ms plus one cycle. It then restores bus power and the card clock together, in the cycle that `done` pulses with status 10 (retry).
- R9: A request is taken only in idle. `busy` is high from acceptance through the cycle before `done`, and `busy` falls together with `done`. The status holds its value between `done` pulses. A request raised while `busy` is high has no effect.
- R10: A wait of n ms lasts n·`CLK_KHZ`+1 cycles. The data lines and the readback pass through a synchronizer `SYNC_DEPTH` flops deep, and each is sampled only at the end of its wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ver_code | input | 8 | Controller revision code; 2 or above enables sequencing |
| req_valid | input | 1 | Request strobe, taken in idle |
| req_low | input | 1 | Target level: 1 = 1.8 V, 0 = 3.3 V |
| dat_lvl | input | DAT_W | Card data line levels |
| sig18_rb | input | 1 | Readback of the 1.8 V enable from the regulator side |
| card_clk_en | output | 1 | Card clock enable |
| sig18_en | output | 1 | 1.8 V signalling enable |
| bus_pwr_en | output | 1 | Card bus power enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 success, 01 error, 10 retry; valid with `done` |

## Verification
The risky overlap is completion and acceptance. A request held high through the end of a sequence meets `done` and the return to idle on one edge, and the new sequence is then accepted on the very next edge. The bench holds `req_valid` high across a full 3.3 V sequence and also pulses it in the middle of a busy period. A behavioural model, advanced every clock, judges `busy`, `done`, `status` and all three controls in every cycle. Explicit checks also count the `done` pulses and confirm that a request made mid-sequence leaves the outputs untouched.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    localparam logic [7:0] VER_V3_CODE    = 8'd2;
    localparam int         SWITCH_WAIT_MS = 5;
    localparam int         CLOCK_WAIT_MS  = 1;
    localparam int         POWER_WAIT_MS  = 1;
    localparam int         MS_W           = $clog2(SWITCH_WAIT_MS + 1);

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_ERR   = 2'b01,
        ST_RETRY = 2'b10
    } vsw_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT33,
        S_GATE,
        S_WAIT18,
        S_WAITCLK,
        S_POWER
    } vsw_state_e;

    function automatic logic [MS_W-1:0] ms_code(input int ms);
        return MS_W'(ms);
    endfunction

    function automatic logic is_v3(input logic [7:0] code);
        return code >= VER_V3_CODE;
    endfunction

endpackage

// File: rtl/vsw_sync.sv
module vsw_sync #(
    parameter int W     = 5,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/vsw_mstimer.sv
module vsw_mstimer
    import vsw_pkg::*;
#(
    parameter int CYC_PER_MS = 250000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            expired
);
    localparam int SUB_W = $clog2(CYC_PER_MS + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_MS - 1);

    logic [SUB_W-1:0] sub_q;
    logic [MS_W-1:0]  ms_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            ms_q  <= '0;
        end else if (load) begin
            sub_q <= '0;
            ms_q  <= load_ms;
        end else if (ms_q != '0) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                ms_q  <= ms_q - 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign expired = (ms_q == '0);

    assert_sub_bound_R10: assert property (@(posedge clk) disable iff (rst)
        sub_q <= SUB_LAST);

    assert_ms_steps_down_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && ms_q != '0) |=> (ms_q == $past(ms_q) || ms_q == $past(ms_q) - 1'b1));
endmodule

// File: rtl/vsw_seq.sv
module vsw_seq
    import vsw_pkg::*;
#(
    parameter int CLK_KHZ    = 250000,
    parameter int SYNC_DEPTH = 2,
    parameter int DAT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       ver_code,
    input  logic             req_valid,
    input  logic             req_low,
    input  logic [DAT_W-1:0] dat_lvl,
    input  logic             sig18_rb,
    output logic             card_clk_en,
    output logic             sig18_en,
    output logic             bus_pwr_en,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    localparam int SET_W = $clog2(SYNC_DEPTH + 1);
    localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SYNC_DEPTH);

    logic [DAT_W:0]   sync_q;
    logic [DAT_W-1:0] dat_s;
    logic             rb_s;

    vsw_sync #(.W(DAT_W + 1), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sig18_rb, dat_lvl}),
        .q   (sync_q)
    );
    assign dat_s = sync_q[DAT_W-1:0];
    assign rb_s  = sync_q[DAT_W];

    logic            tm_load;
    logic [MS_W-1:0] tm_ms;
    logic            tm_exp;

    vsw_mstimer #(.CYC_PER_MS(CLK_KHZ)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tm_load),
        .load_ms (tm_ms),
        .expired (tm_exp)
    );

    vsw_state_e       state_q, state_d;
    vsw_status_e      stat_q, stat_d;
    logic             clk_q, clk_d;
    logic             s18_q, s18_d;
    logic             pwr_q, pwr_d;
    logic             busy_q, busy_d;
    logic             done_q, done_d;
    logic [SET_W-1:0] settle_q, settle_d;
    logic             fail;

    always_comb begin
        state_d  = state_q;
        stat_d   = stat_q;
        clk_d    = clk_q;
        s18_d    = s18_q;
        pwr_d    = pwr_q;
        busy_d   = busy_q;
        done_d   = 1'b0;
        settle_d = settle_q;
        tm_load  = 1'b0;
        tm_ms    = '0;
        fail     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!is_v3(ver_code) || (req_low && s18_q)) begin
                        done_d = 1'b1;
                        stat_d = ST_OK;
                    end else if (!req_low) begin
                        s18_d   = 1'b0;
                        tm_load = 1'b1;
                        tm_ms   = ms_code(SWITCH_WAIT_MS);
                        busy_d  = 1'b1;
                        state_d = S_WAIT33;
                    end else begin
                        clk_d    = 1'b0;
                        settle_d = '0;
                        busy_d   = 1'b1;
                        state_d  = S_GATE;
                    end
                end
            end
            S_WAIT33: begin
                if (tm_exp) begin
                    done_d  = 1'b1;
                    stat_d  = rb_s ? ST_ERR : ST_OK;
                    busy_d  = 1'b0;
                    state_d = S_IDLE;
                end
            end
            S_GATE: begin
                if (settle_q != SETTLE_LAST) begin
                    settle_d = settle_q + 1'b1;
                end else if (dat_s == '0) begin
                    s18_d   = 1'b1;
                    tm_load = 1'b1;
                    tm_ms   = ms_code(SWITCH_WAIT_MS);
                    state_d = S_WAIT18;
                end else begin
                    fail = 1'b1;
                end
            end
            S_WAIT18: begin
                if (tm_exp) begin
                    if (rb_s) begin
                        clk_d   = 1'b1;
                        tm_load = 1'b1;
                        tm_ms   = ms_code(CLOCK_WAIT_MS);
                        state_d = S_WAITCLK;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            S_WAITCLK: begin
                if (tm_exp) begin
                    if (&dat_s) begin
                        done_d  = 1'b1;
                        stat_d  = ST_OK;
                        busy_d  = 1'b0;
                        state_d = S_IDLE;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            S_POWER: begin
                if (tm_exp) begin
                    pwr_d   = 1'b1;
                    clk_d   = 1'b1;
                    done_d  = 1'b1;
                    stat_d  = ST_RETRY;
                    busy_d  = 1'b0;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (fail) begin
            s18_d   = 1'b0;
            pwr_d   = 1'b0;
            tm_load = 1'b1;
            tm_ms   = ms_code(POWER_WAIT_MS);
            state_d = S_POWER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            stat_q   <= ST_OK;
            clk_q    <= 1'b1;
            s18_q    <= 1'b0;
            pwr_q    <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            stat_q   <= stat_d;
            clk_q    <= clk_d;
            s18_q    <= s18_d;
            pwr_q    <= pwr_d;
            busy_q   <= busy_d;
            done_q   <= done_d;
            settle_q <= settle_d;
        end
    end

    assign card_clk_en = clk_q;
    assign sig18_en    = s18_q;
    assign bus_pwr_en  = pwr_q;
    assign busy        = busy_q;
    assign done        = done_q;
    assign status      = stat_q;

    assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_power_off_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_pwr_en |-> busy);

    assert_retry_restores_R8: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_RETRY) |-> (bus_pwr_en && card_clk_en && !sig18_en));

    assert_enable_clock_off_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sig18_en) |-> !card_clk_en);

    assert_legacy_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && req_valid && !is_v3(ver_code))
        |=> (done && !busy && $stable(sig18_en) && $stable(card_clk_en) && $stable(bus_pwr_en)));

    assert_status_code_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'b11));
endmodule

// File: tb/test_vsw_seq.sv
`timescale 1ns/1ps
module test_vsw_seq;
    localparam int K  = 4;
    localparam int SD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ver_code = 8'd2;
    logic       req_valid = 1'b0;
    logic       req_low = 1'b0;
    logic [3:0] dat_on = 4'hF;
    logic [3:0] dat_off = 4'h0;
    logic       rb_refuse = 1'b0;
    logic       rb_stuck = 1'b0;
    logic [3:0] dat_lvl;
    logic       sig18_rb;
    logic       card_clk_en, sig18_en, bus_pwr_en, busy, done;
    logic [1:0] status;

    always #2 clk = ~clk;

    assign dat_lvl  = card_clk_en ? dat_on : dat_off;
    assign sig18_rb = rb_stuck ? 1'b1 : (rb_refuse ? 1'b0 : sig18_en);

    vsw_seq #(.CLK_KHZ(K), .SYNC_DEPTH(SD), .DAT_W(4)) i_vsw_seq (
        .clk         (clk),
        .rst         (rst),
        .ver_code    (ver_code),
        .req_valid   (req_valid),
        .req_low     (req_low),
        .dat_lvl     (dat_lvl),
        .sig18_rb    (sig18_rb),
        .card_clk_en (card_clk_en),
        .sig18_en    (sig18_en),
        .bus_pwr_en  (bus_pwr_en),
        .busy        (busy),
        .done        (done),
        .status      (status)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    int         m_ph, m_cnt;
    logic       m_clk, m_s18, m_pwr, m_busy, m_done;
    logic [1:0] m_st;
    logic [3:0] h1d, h2d, sd_v;
    logic       h1r, h2r, sr_v;

    task automatic m_power();
        m_s18 = 1'b0;
        m_pwr = 1'b0;
        m_cnt = K;
        m_ph  = 5;
    endtask

    task automatic m_finish(input logic [1:0] st);
        m_done = 1'b1;
        m_st   = st;
        m_busy = 1'b0;
        m_ph   = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_clk = 1'b1; m_s18 = 1'b0; m_pwr = 1'b1;
            m_busy = 1'b0; m_done = 1'b0; m_st = 2'b00;
            h1d = '0; h2d = '0; h1r = 1'b0; h2r = 1'b0;
        end else begin
            sd_v = h2d; sr_v = h2r;
            h2d = h1d; h1d = dat_lvl;
            h2r = h1r; h1r = sig18_rb;
            m_done = 1'b0;
            case (m_ph)
                0: if (req_valid) begin
                    if (ver_code < 8'd2 || (req_low && m_s18)) begin
                        m_done = 1'b1; m_st = 2'b00;
                    end else if (!req_low) begin
                        m_s18 = 1'b0; m_cnt = 5 * K; m_ph = 1; m_busy = 1'b1;
                    end else begin
                        m_clk = 1'b0; m_cnt = SD; m_ph = 2; m_busy = 1'b1;
                    end
                end
                1: if (m_cnt > 0) m_cnt--; else m_finish(sr_v ? 2'b01 : 2'b00);
                2: if (m_cnt > 0) m_cnt--;
                   else if (sd_v == 4'h0) begin m_s18 = 1'b1; m_cnt = 5 * K; m_ph = 3; end
                   else m_power();
                3: if (m_cnt > 0) m_cnt--;
                   else if (sr_v) begin m_clk = 1'b1; m_cnt = K; m_ph = 4; end
                   else m_power();
                4: if (m_cnt > 0) m_cnt--;
                   else if (sd_v == 4'hF) m_finish(2'b00);
                   else m_power();
                5: if (m_cnt > 0) m_cnt--;
                   else begin m_pwr = 1'b1; m_clk = 1'b1; m_finish(2'b10); end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 card clock enable vs model", int'(card_clk_en), int'(m_clk));
            chk("R6 1.8V enable vs model", int'(sig18_en), int'(m_s18));
            chk("R8 bus power vs model", int'(bus_pwr_en), int'(m_pwr));
            chk("R9 busy vs model", int'(busy), int'(m_busy));
            chk("R9 done vs model", int'(done), int'(m_done));
            chk("R3 status vs model", int'(status), int'(m_st));
        end
    end

    int busy_cyc = 0;
    int pwr_low_cyc = 0;
    int done_cnt = 0;
    int wd_cyc = 0;

    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (!bus_pwr_en) pwr_low_cyc++;
        if (done) done_cnt++;
        wd_cyc++;
        if (wd_cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_req(input logic low, output logic [1:0] st);
        @(negedge clk);
        busy_cyc = 0;
        pwr_low_cyc = 0;
        req_low = low;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        st = status;
    endtask

    logic [1:0] st;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 card clock after reset", int'(card_clk_en), 1);
        chk("R1 bus power after reset", int'(bus_pwr_en), 1);
        chk("R1 1.8V enable after reset", int'(sig18_en), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);

        // R2 legacy revision
        ver_code = 8'd1;
        run_req(1'b1, st);
        chk("R2 legacy status", int'(st), 0);
        chk("R2 legacy busy cycles", busy_cyc, 0);
        chk("R2 legacy 1.8V enable", int'(sig18_en), 0);
        chk("R2 legacy card clock", int'(card_clk_en), 1);
        ver_code = 8'd2;

        // R3 3.3V request, readback clear / stuck
        run_req(1'b0, st);
        chk("R3 3.3V success status", int'(st), 0);
        chk("R10 3.3V busy length", busy_cyc, 5 * K + 1);
        rb_stuck = 1'b1;
        run_req(1'b0, st);
        chk("R3 3.3V stuck readback status", int'(st), 1);
        rb_stuck = 1'b0;

        // R7 full 1.8V switch
        run_req(1'b1, st);
        chk("R7 1.8V success status", int'(st), 0);
        chk("R6 1.8V enable held", int'(sig18_en), 1);
        chk("R7 card clock back on", int'(card_clk_en), 1);
        chk("R10 1.8V busy length", busy_cyc, (SD + 1) + (5 * K + 1) + (K + 1));

        // R4 already at 1.8V
        run_req(1'b1, st);
        chk("R4 no-op status", int'(st), 0);
        chk("R4 no-op busy cycles", busy_cyc, 0);
        chk("R4 1.8V enable unchanged", int'(sig18_en), 1);

        run_req(1'b0, st);
        chk("R3 back to 3.3V status", int'(st), 0);
        chk("R3 1.8V enable cleared", int'(sig18_en), 0);

        // R5 data lines not idle after clock gating
        dat_off = 4'h2;
        run_req(1'b1, st);
        chk("R5 busy lines give retry", int'(st), 2);
        chk("R8 power low length", pwr_low_cyc, K + 1);
        chk("R8 power restored", int'(bus_pwr_en), 1);
        chk("R8 clock restored", int'(card_clk_en), 1);
        chk("R8 enable cleared", int'(sig18_en), 0);
        chk("R10 gate-fail busy length", busy_cyc, (SD + 1) + (K + 1));
        dat_off = 4'h0;

        // R6 regulator refuses
        rb_refuse = 1'b1;
        run_req(1'b1, st);
        chk("R6 refused readback gives retry", int'(st), 2);
        chk("R8 enable cleared after refusal", int'(sig18_en), 0);
        rb_refuse = 1'b0;

        // R7 wrong levels after clock returns
        dat_on = 4'h5;
        run_req(1'b1, st);
        chk("R7 bad final levels give retry", int'(st), 2);
        dat_on = 4'hF;

        // R9 request held across completion
        @(negedge clk);
        done_cnt = 0;
        req_low = 1'b0;
        req_valid = 1'b1;
        repeat (30) @(negedge clk);
        req_valid = 1'b0;
        chk("R9 dones in held window", done_cnt, 1);
        while (!done) @(negedge clk);
        chk("R9 second sequence status", int'(status), 0);

        // R9 request during busy ignored
        @(negedge clk);
        req_low = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_low = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R9 mid-busy request ignored busy", int'(busy), 0);
        chk("R9 mid-busy request ignored clock", int'(card_clk_en), 1);
        chk("R9 mid-busy request ignored enable", int'(sig18_en), 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule